// File: doc/BRIEF.md
# Peripheral Bus Transfer Rule Monitor

This block is a passive checker that sits beside a simple two-phase peripheral bus (APB-style) on the completer side. It watches select, enable, direction, address, write data and read data, and drives none of them. Every cycle it tests six timing rules. A rule that is broken sets a sticky flag for that rule, and an error counter records how many rule breaks have been seen. The bus is assumed to have no wait states, so every access phase lasts exactly one cycle.

The monitor is placed in a chip next to a bus segment. A controller or a test program reads the flag vector and the counter, then clears both with a one-cycle clear pulse. Checking stops while reset is asserted and starts again on the first clock edge after reset is released. Address and direction are captured in each access cycle. While the bus is idle, these captured values are compared against the bus until the next setup cycle. Before the first access after reset nothing has been captured, so that comparison is skipped.

Top module: `apb_rule_monitor`

## Requirements
- R1: After an edge where select is seen rising, enable must be seen rising at the next edge. If it is not, flag bit 0 of `rule_err` is set.
- R2: If enable is high on two edges in a row after it rose, flag bit 1 is set on the second of those edges.
- R3: A setup cycle (select high, enable low) followed at once by an access cycle (select and enable high) must show the same write data in both cycles. Otherwise flag bit 2 is set, whatever the direction.
- R4: After an access, every idle cycle (select low) before the next setup cycle must show the address captured during that access. Each differing cycle sets flag bit 3. Until the first access after reset there is nothing to compare, so no such check is made.
- R5: The direction input has the same hold rule as the address, and a break sets flag bit 4. The same exemption after reset applies.
- R6: In a cycle where enable rises while direction is low (read), read data must differ from its value at the previous edge. Otherwise flag bit 5 is set.
- R7: Flags are sticky until cleared. While reset is low, all flags and the counter read zero and no rule is recorded.
- R8: A clear pulse sampled high zeroes all flags and the counter at that edge. Violations seen in that same cycle are discarded.
- R9: At each edge the counter adds the number of rules broken in that cycle. It saturates at its all-ones value and never wraps. The default width is 16 bits.
- R10: Legal back-to-back and gapped reads and writes, with address and direction held while idle, set no flag and leave the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all checks sample on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; suppresses checking |
| clr | input | 1 | Synchronous clear of flags and counter |
| bus_sel | input | 1 | Bus select of the monitored completer |
| bus_enable | input | 1 | Access-phase strobe |
| bus_write | input | 1 | Direction, 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Transfer address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data returned by the completer |
| rule_err | output | 6 | Sticky per-rule flags, bit n for rule n as listed above |
| err_total | output | CNT_W | Saturating count of rule breaks |

## Verification
Assertions check on every cycle that flags stay set until a clear, that a clear zeroes flags and counter, and that the counter never decreases or wraps. They also check that each raised detection agrees with the bus history it depends on (an enable high on the previous edge, a select seen earlier, read data unchanged). Which rule fires in which cycle, and the first-transfer exemption, can only be shown by the bench. It drives stalled setups, doubled access phases, moved data, address and direction, frozen read data and mid-run resets, and compares the flags and counter with an independent cycle model. Saturation is reached by running the bench with a narrow counter.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;

  localparam int unsigned NUM_RULES = 6;

  // bit position of each rule inside the flag vector
  typedef enum int unsigned {
    RULE_HANDSHAKE = 0,
    RULE_ACC_LEN   = 1,
    RULE_WDATA     = 2,
    RULE_ADDR_HOLD = 3,
    RULE_DIR_HOLD  = 4,
    RULE_RDATA     = 5
  } rule_e;

  typedef logic [NUM_RULES-1:0] rule_vec_t;

  // number of rules broken in one cycle
  function automatic int unsigned rules_hit(rule_vec_t v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < NUM_RULES; i++) begin
      n += {31'd0, v[i]};
    end
    return n;
  endfunction

endpackage

// File: rtl/apb_mon_history.sv
module apb_mon_history #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              enable,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  output logic              sel_q,
  output logic              en_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              sel_rose_q,
  output logic              en_rose_q,
  output logic              hold_armed,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_write
);

  logic sel_rose_now;
  logic en_rose_now;
  logic setup_now;
  logic access_now;

  assign sel_rose_now = sel & ~sel_q;
  assign en_rose_now  = enable & ~en_q;
  assign setup_now    = sel & ~enable;
  assign access_now   = sel & enable;

  // plain previous-cycle copies, sampled even in reset so that the
  // first edge after reset compares against real bus values
  always_ff @(posedge clk) begin
    sel_q   <= sel;
    en_q    <= enable;
    wdata_q <= wdata;
    rdata_q <= rdata;
  end

  // edge memories that arm the next-cycle checks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_rose_q <= 1'b0;
      en_rose_q  <= 1'b0;
    end else begin
      sel_rose_q <= sel_rose_now;
      en_rose_q  <= en_rose_now;
    end
  end

  // capture of the last access; armed until the next setup cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_armed <= 1'b0;
      cap_addr   <= '0;
      cap_write  <= 1'b0;
    end else if (access_now) begin
      hold_armed <= 1'b1;
      cap_addr   <= addr;
      cap_write  <= write;
    end else if (setup_now) begin
      hold_armed <= 1'b0;
    end
  end

endmodule

// File: rtl/apb_mon_rules.sv
module apb_mon_rules
  import apb_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              enable,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  input  logic              sel_q,
  input  logic              en_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [DATA_W-1:0] rdata_q,
  input  logic              sel_rose_q,
  input  logic              en_rose_q,
  input  logic              hold_armed,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              cap_write,
  output rule_vec_t         viol
);

  logic en_rose_now;
  logic was_setup;
  logic is_access;
  logic idle_watch;

  assign en_rose_now = enable & ~en_q;
  assign was_setup   = sel_q & ~en_q;
  assign is_access   = sel & enable;
  assign idle_watch  = hold_armed & ~sel;

  always_comb begin
    viol = '0;
    viol[RULE_HANDSHAKE] = sel_rose_q & ~en_rose_now;
    viol[RULE_ACC_LEN]   = en_rose_q & enable;
    viol[RULE_WDATA]     = was_setup & is_access & (wdata != wdata_q);
    viol[RULE_ADDR_HOLD] = idle_watch & (addr != cap_addr);
    viol[RULE_DIR_HOLD]  = idle_watch & (write != cap_write);
    viol[RULE_RDATA]     = en_rose_now & ~write & (rdata == rdata_q);
  end

  // R1
  handshake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_HANDSHAKE] |-> $past(sel))
    else $error("handshake flag without a prior select");

  // R2
  acc_len_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_ACC_LEN] |-> ($past(enable) && enable))
    else $error("access length flag without two enable cycles");

  // R6
  rdata_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_RDATA] |-> (!write && rdata == $past(rdata)))
    else $error("read data flag with moving data");

endmodule

// File: rtl/apb_mon_flags.sv
module apb_mon_flags
  import apb_mon_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  rule_vec_t        viol,
  output rule_vec_t        flags,
  output logic [CNT_W-1:0] count
);

  localparam int unsigned     SUM_W   = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_add(logic [CNT_W-1:0] cur,
                                               int unsigned inc);
    logic [SUM_W-1:0] inc_w;
    logic [SUM_W-1:0] sum;
    inc_w = SUM_W'(inc);
    sum   = {1'b0, cur} + inc_w;
    return sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  endfunction

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (clr)    flags[g] <= 1'b0;
      else if (viol[g]) flags[g] <= 1'b1;
    end

    // R7
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !clr) |=> flags[g])
      else $error("flag dropped without clear");
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= sat_add(count, rules_hit(viol));
  end

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == '0 && count == '0))
    else $error("clear left state behind");

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX)
    else $error("counter left saturation");

  // R9
  monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> count >= $past(count))
    else $error("counter decreased without clear");

endmodule

// File: rtl/apb_rule_monitor.sv
module apb_rule_monitor
  import apb_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 bus_sel,
  input  logic                 bus_enable,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_RULES-1:0] rule_err,
  output logic [CNT_W-1:0]     err_total
);

  logic              sel_q, en_q, sel_rose_q, en_rose_q;
  logic              hold_armed, cap_write;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [ADDR_W-1:0] cap_addr;
  rule_vec_t         viol;
  rule_vec_t         flags;

  apb_mon_history #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_hist (
    .clk(clk), .rst_n(rst_n),
    .sel(bus_sel), .enable(bus_enable), .write(bus_write),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .sel_q(sel_q), .en_q(en_q), .wdata_q(wdata_q), .rdata_q(rdata_q),
    .sel_rose_q(sel_rose_q), .en_rose_q(en_rose_q),
    .hold_armed(hold_armed), .cap_addr(cap_addr), .cap_write(cap_write)
  );

  apb_mon_rules #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rules (
    .clk(clk), .rst_n(rst_n),
    .sel(bus_sel), .enable(bus_enable), .write(bus_write),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .sel_q(sel_q), .en_q(en_q), .wdata_q(wdata_q), .rdata_q(rdata_q),
    .sel_rose_q(sel_rose_q), .en_rose_q(en_rose_q),
    .hold_armed(hold_armed), .cap_addr(cap_addr), .cap_write(cap_write),
    .viol(viol)
  );

  apb_mon_flags #(.CNT_W(CNT_W)) i_flags (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .viol(viol), .flags(flags), .count(err_total)
  );

  assign rule_err = flags;

  // R7
  flag_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && rule_err != '0 && $past(rule_err) == '0) |-> err_total != '0)
    else $error("flag raised with zero count");

endmodule

// File: tb/test_apb_rule_monitor.sv
module test_apb_rule_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 6;
  localparam int CMAX       = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, clr = 1'b0;
  logic        b_sel = 1'b0, b_en = 1'b0, b_wr = 1'b0;
  logic [31:0] b_addr = '0, b_wd = '0, b_rd = '0;
  logic [5:0]  rule_err;
  logic [CW-1:0] err_total;

  int checks = 0, fails = 0;

  apb_rule_monitor #(.ADDR_W(32), .DATA_W(32), .CNT_W(CW)) i_apb_rule_monitor (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .bus_sel(b_sel), .bus_enable(b_en), .bus_write(b_wr),
    .bus_addr(b_addr), .bus_wdata(b_wd), .bus_rdata(b_rd),
    .rule_err(rule_err), .err_total(err_total)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model (built from R1..R10) ------------
  string tag [6] = '{"R1", "R2", "R3", "R4", "R5", "R6"};
  logic  p_sel, p_en, p_sel_up, p_en_up, armed, k_wr;
  logic [31:0] p_wd, p_rd, k_addr;
  logic [5:0]  e_flags;
  int          e_cnt;

  function automatic int bits6(logic [5:0] v);
    int n = 0;
    for (int i = 0; i < 6; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic void model_step();
    logic [5:0] br;
    br = '0;
    if (rst_n) begin
      if (p_sel_up && !(b_en && !p_en))              br[0] = 1'b1; // R1
      if (p_en_up && b_en)                           br[1] = 1'b1; // R2
      if (p_sel && !p_en && b_sel && b_en && b_wd != p_wd) br[2] = 1'b1; // R3
      if (armed && !b_sel && b_addr != k_addr)       br[3] = 1'b1; // R4
      if (armed && !b_sel && b_wr != k_wr)           br[4] = 1'b1; // R5
      if (b_en && !p_en && !b_wr && b_rd == p_rd)    br[5] = 1'b1; // R6
      if (clr) begin e_flags = '0; e_cnt = 0; end    // R8
      else begin
        e_flags |= br;                               // R7
        e_cnt += bits6(br);                          // R9
        if (e_cnt > CMAX) e_cnt = CMAX;
      end
      if (b_sel && b_en) begin armed = 1'b1; k_addr = b_addr; k_wr = b_wr; end
      else if (b_sel) armed = 1'b0;
      p_sel_up = b_sel && !p_sel;
      p_en_up  = b_en && !p_en;
    end else begin
      e_flags = '0; e_cnt = 0; armed = 1'b0; p_sel_up = 1'b0; p_en_up = 1'b0;
    end
    p_sel = b_sel; p_en = b_en; p_wd = b_wd; p_rd = b_rd;
  endfunction

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    checks++;
    for (int i = 0; i < 6; i++) begin
      if (rule_err[i] !== e_flags[i]) begin
        fails++;
        $display("FAIL %s flag bit %0d actual=%0b expected=%0b", tag[i], i, rule_err[i], e_flags[i]);
      end
    end
    checks++;
    if (err_total !== CW'(e_cnt)) begin
      fails++;
      $display("FAIL R9 counter actual=%0d expected=%0d", err_total, e_cnt);
    end
  endtask

  task automatic expect_state(logic [5:0] f, int c, string req);
    checks++;
    if (rule_err !== f || err_total !== CW'(c)) begin
      fails++;
      $display("FAIL %s flags=%b count=%0d expected flags=%b count=%0d", req, rule_err, err_total, f, c);
    end
  endtask

  task automatic clear_pulse();
    clr = 1'b1; b_sel = 1'b0; b_en = 1'b0;
    tick();
    clr = 1'b0;
    expect_state(6'b0, 0, "R8");
  endtask

  // fault kinds: 0 none, 1 stalled setup, 2 doubled access,
  // 3 write data moved, 4 address moved, 5 direction moved, 6 read data frozen
  task automatic xfer(logic w, logic [31:0] a, logic [31:0] wd, logic [31:0] rd,
                      int fault, int gap);
    b_sel = 1'b1; b_en = 1'b0; b_wr = w; b_addr = a; b_wd = wd;
    tick();
    if (fault == 1) tick();
    b_en = 1'b1;
    if (fault == 3) b_wd = wd ^ 32'h1;
    if (!w && fault != 6) b_rd = (rd == b_rd) ? (rd ^ 32'h1) : rd;
    tick();
    if (fault == 2) tick();
    b_sel = 1'b0; b_en = 1'b0;
    for (int g = 0; g < gap; g++) begin
      if (g == 0 && fault == 4) b_addr = b_addr ^ 32'h4;
      if (g == 0 && fault == 5) b_wr = ~b_wr;
      tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    p_sel = 0; p_en = 0; p_sel_up = 0; p_en_up = 0; armed = 0; k_wr = 0;
    p_wd = 0; p_rd = 0; k_addr = 0; e_flags = 0; e_cnt = 0;
    #2;
    for (int i = 0; i < 3; i++) tick();
    expect_state(6'b0, 0, "R7 reset state");
    rst_n = 1'b1;

    // R4 / R5 first transfer exempt, R10 clean traffic
    xfer(1'b1, 32'h100, 32'hAAAA_0001, 32'h0, 0, 2);
    expect_state(6'b0, 0, "R4 first transfer exempt");
    xfer(1'b0, 32'h104, 32'h0, 32'h1234_5678, 0, 0);
    xfer(1'b1, 32'h108, 32'h5555_0002, 32'h0, 0, 3);
    expect_state(6'b0, 0, "R10 clean back-to-back and gapped");

    // R1 stalled setup; R7 stays set afterwards
    clear_pulse();
    xfer(1'b1, 32'h10, 32'h1, 32'h0, 1, 2);
    expect_state(6'b000001, 1, "R1 stalled setup");
    // R2 doubled access
    clear_pulse();
    xfer(1'b1, 32'h14, 32'h2, 32'h0, 2, 1);
    expect_state(6'b000010, 1, "R2 doubled access");
    // R3 write data moved
    clear_pulse();
    xfer(1'b1, 32'h18, 32'h3, 32'h0, 3, 1);
    expect_state(6'b000100, 1, "R3 write data moved");
    // R4 address moved for two idle cycles
    clear_pulse();
    xfer(1'b1, 32'h1C, 32'h4, 32'h0, 4, 2);
    expect_state(6'b001000, 2, "R4 address moved while idle");
    // R5 direction moved for two idle cycles
    clear_pulse();
    xfer(1'b1, 32'h20, 32'h5, 32'h0, 5, 2);
    expect_state(6'b010000, 2, "R5 direction moved while idle");
    // R6 read data frozen
    clear_pulse();
    xfer(1'b0, 32'h24, 32'h0, 32'h0, 6, 1);
    expect_state(6'b100000, 1, "R6 read data unchanged");

    // R9 two rules in one cycle, then saturation
    clear_pulse();
    xfer(1'b1, 32'h30, 32'h6, 32'h0, 0, 1);
    b_addr = 32'h34; b_wr = 1'b0;
    tick();
    expect_state(6'b011000, 2, "R9 two rules one cycle");
    for (int i = 0; i < 40; i++) tick();
    expect_state(6'b011000, CMAX, "R9 saturated");
    tick();
    expect_state(6'b011000, CMAX, "R9 no wrap");
    b_addr = 32'h30; b_wr = 1'b1;
    clear_pulse();
    tick();
    expect_state(6'b0, 0, "R8 cleared and quiet");

    // R7 reset mid-run suppresses checks; R4 exemption returns
    b_addr = 32'h999;
    tick();
    expect_state(6'b001000, 1, "R4 before reset");
    rst_n = 1'b0;
    tick();
    expect_state(6'b0, 0, "R7 reset clears");
    b_wr = 1'b0; b_addr = 32'h777;
    tick();
    expect_state(6'b0, 0, "R7 suppressed in reset");
    rst_n = 1'b1;
    b_addr = 32'h555;
    tick();
    b_wr = 1'b1;
    tick();
    expect_state(6'b0, 0, "R4 R5 exempt after reset");

    // random mix of clean and faulty transfers
    for (int n = 0; n < 1500; n++) begin
      int f;
      if ($urandom_range(0, 15) == 0) clear_pulse();
      f = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 6)) : 0;
      xfer($urandom_range(0, 1) == 1, $urandom & 32'hFFFC, $urandom, $urandom,
           f, (f == 4 || f == 5) ? int'($urandom_range(1, 3)) : int'($urandom_range(0, 3)));
    end
    clear_pulse();

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule